// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Generator

This block supervises a host's serial-peripheral bus by watching its active-low chip-select line. Every falling edge of chip select counts as bus activity and restarts an idle counter. If the counter reaches the selected time-out before any new activity arrives, the block drives a reset pulse of fixed width. When the pulse ends, counting begins again from zero.

A two-bit period select chooses the time-out. It carries the two watchdog bits of the host-written status register, so a neighbour decodes it. Three of its codes pick long, middle and short periods, and the fourth code switches the watchdog off. A supply-low input stands in for the voltage-trip comparator. While that input is high it forces reset. After it drops, reset stays asserted for one more full pulse width.

The controller is a four-state machine:
- `ST_COUNT` counts idle cycles.
- `ST_PULSE` drives the timed reset pulse.
- `ST_HOLD` follows supply-low.
- `ST_OFF` is the disabled state.

Its transitions are:
- COUNT→PULSE on time-out.
- COUNT→OFF and PULSE→OFF when the code is 11.
- PULSE→COUNT when the pulse ends.
- OFF→COUNT when a period code is selected.
- HOLD→PULSE when supply-low clears.
- Any state→HOLD on supply-low.

Top module: `bus_watchdog_rst`

## Requirements
- R1: While `rst_n` is low, `wd_reset` is 0 and the idle counter is zero. With no activity, `wd_reset` rises on the cycle that ends the selected period after reset release.
- R2: `period_sel` = 00 selects `LONG_CYC` cycles, 01 selects `MID_CYC`, and 10 selects `SHORT_CYC`. `wd_reset` rises exactly that many cycles after the counter restarts. A registered activity edge or code change restarts the counter one cycle after the input changes.
- R3: `period_sel` = 11 disables the watchdog. Once `wd_reset` is low, it stays low for as long as the code stays 11 and `supply_low` stays 0.
- R4: A falling edge of `cs_n` while counting restarts the idle counter from zero.
- R5: A change of `period_sel` while counting restarts the idle counter from zero.
- R6: A time-out pulse lasts exactly `PULSE_CYC` cycles. The idle counter then restarts from zero.
- R7: While `supply_low` is 1, `wd_reset` is 1 from the next cycle on.
- R8: After `supply_low` returns to 0, `wd_reset` stays 1 for `PULSE_CYC` further cycles. This count starts after the cycle in which the machine leaves the hold state.
- R9: A `cs_n` falling edge or a `period_sel` change during a pulse neither shortens nor lengthens it. Supply-low during a pulse takes over and behaves as in R8.
- R10: A rising edge of `cs_n`, or `cs_n` held low, is not activity and does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Bus chip select, active low; its falling edge is activity |
| period_sel | input | 2 | Watchdog period code from the status register |
| supply_low | input | 1 | Supply-below-threshold indication, forces reset |
| wd_reset | output | 1 | Reset output, active high |

## Verification
The hardest cases to reach from the ports are the ones where a second event lands inside a running pulse:
- a chip-select edge,
- a period change,
- a supply-low assertion.

Each of these must leave the pulse length and the following count exactly as R8 and R9 state. The stimulus reaches them by scheduling every input change at an absolute cycle number computed from the expected time-outs. A single run therefore places a select change and a chip-select edge two cycles into one pulse, and a supply-low assertion two cycles into a later pulse. For each of these the scoreboard predicts the cycle of the next rising and falling edge of the reset output.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2,
        ST_OFF   = 2'd3
    } wdg_state_t;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/wdg_activity.sv
module wdg_activity #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [SEL_W-1:0] period_sel,
    output logic             act_edge,
    output logic             sel_chg
);
    logic             cs_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sel_q <= '0;
        end else begin
            cs_q  <= cs_n;
            sel_q <= period_sel;
        end
    end

    // only a high-to-low transition of chip select is activity
    assign act_edge = cs_q & ~cs_n;
    assign sel_chg  = (sel_q != period_sel);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bus_watchdog_rst.sv
module bus_watchdog_rst
    import wdg_pkg::*;
#(
    parameter int LONG_CYC  = 120,
    parameter int MID_CYC   = 60,
    parameter int SHORT_CYC = 30,
    parameter int PULSE_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] period_sel,
    input  logic       supply_low,
    output logic       wd_reset
);
    localparam int MAX_A  = (LONG_CYC > MID_CYC) ? LONG_CYC : MID_CYC;
    localparam int MAX_B  = (SHORT_CYC > PULSE_CYC) ? SHORT_CYC : PULSE_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] MID_END   = CNT_W'(MID_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);

    wdg_state_t       state, state_nx;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idle_end;
    logic             act_edge, sel_chg, sel_off;

    wdg_activity #(.SEL_W(2)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .period_sel (period_sel),
        .act_edge   (act_edge),
        .sel_chg    (sel_chg)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    assign sel_off = (period_sel == SEL_OFF);

    always_comb begin
        unique case (period_sel)
            SEL_LONG:  idle_end = LONG_END;
            SEL_MID:   idle_end = MID_END;
            SEL_SHORT: idle_end = SHORT_END;
            default:   idle_end = LONG_END;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nx;
    end

    // next state and counter control
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        unique case (state)
            ST_COUNT: begin
                if (supply_low) begin
                    state_nx = ST_HOLD;
                    cnt_clr  = 1'b1;
                end else if (sel_off) begin
                    state_nx = ST_OFF;
                    cnt_clr  = 1'b1;
                end else if (act_edge || sel_chg) begin
                    cnt_clr  = 1'b1;
                end else if (cnt == idle_end) begin
                    state_nx = ST_PULSE;
                    cnt_clr  = 1'b1;
                end
            end
            ST_PULSE: begin
                if (supply_low) begin
                    state_nx = ST_HOLD;
                    cnt_clr  = 1'b1;
                end else if (cnt == PULSE_END) begin
                    state_nx = sel_off ? ST_OFF : ST_COUNT;
                    cnt_clr  = 1'b1;
                end
            end
            ST_HOLD: begin
                cnt_clr = 1'b1;
                if (!supply_low) state_nx = ST_PULSE;
            end
            ST_OFF: begin
                cnt_clr = 1'b1;
                if (supply_low)    state_nx = ST_HOLD;
                else if (!sel_off) state_nx = ST_COUNT;
            end
            default: begin
                state_nx = ST_COUNT;
                cnt_clr  = 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PULSE, ST_HOLD: wd_reset = 1'b1;
            default:           wd_reset = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int PULSE_CYC = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [1:0] period_sel,
    input logic       supply_low,
    input logic       wd_reset
);
    int hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hi_run <= 0;
        else if (wd_reset && !supply_low) hi_run <= hi_run + 1;
        else                              hi_run <= 0;
    end

    AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> wd_reset); // R7

    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_low) |=> wd_reset); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel == 2'b11 && !supply_low && !wd_reset) |=> !wd_reset); // R3

    AST_ACT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(cs_n) && !wd_reset && !supply_low) |=> !wd_reset); // R4

    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel != $past(period_sel) && !wd_reset && !supply_low) |=> !wd_reset); // R5

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= PULSE_CYC + 1); // R6
endmodule

bind bus_watchdog_rst wdg_checker #(.PULSE_CYC(PULSE_CYC)) u_wdg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .period_sel (period_sel),
    .supply_low (supply_low),
    .wd_reset   (wd_reset)
);

// File: tb/bus_watchdog_rst_bench.sv
module bus_watchdog_rst_bench;
    localparam int L = 120;
    localparam int M = 60;
    localparam int S = 30;
    localparam int P = 6;

    typedef struct {
        bit    level;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] period_sel = 2'b00;
    logic       supply_low = 1'b0;
    logic       wd_reset;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic prev = 1'b0;
    exp_t q[$];

    bus_watchdog_rst #(.LONG_CYC(L), .MID_CYC(M), .SHORT_CYC(S), .PULSE_CYC(P)) u_bus_watchdog_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .period_sel (period_sel),
        .supply_low (supply_low),
        .wd_reset   (wd_reset)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_edge(input bit level, input int at, input string req);
        exp_t e;
        e.level = level;
        e.cyc   = at;
        e.req   = req;
        q.push_back(e);
    endtask

    task automatic at_cycle(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: wd_reset=%b expected %b at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // scoreboard monitor: every output edge must match the next expected item
    always @(negedge clk) begin
        if (rst_n && wd_reset !== prev) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL unexpected: wd_reset edge to %b at cycle %0d, expected none", wd_reset, cyc);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.level !== wd_reset || e.cyc != cyc) begin
                    failures++;
                    $display("FAIL %s: edge to %b at cycle %0d, expected edge to %b at cycle %0d",
                             e.req, wd_reset, cyc, e.level, e.cyc);
                end
            end
        end
        prev = wd_reset;
    end

    initial begin
        int c0;
        @(negedge clk);
        at_cycle(4);
        chk("R1 reset state", wd_reset, 1'b0);
        rst_n = 1'b1;
        c0 = cyc;
        chk("R1 after release", wd_reset, 1'b0);
        // R1/R2 long idle period from release, R6 pulse width
        expect_edge(1'b1, c0 + L, "R1 R2 long time-out");
        expect_edge(1'b0, c0 + L + P, "R6 pulse width");
        // R4 activity restarts; R10 rising edge and steady low do not
        expect_edge(1'b1, c0 + 150 + 1 + L, "R4 R10 restart on falling edge only");
        expect_edge(1'b0, c0 + 150 + 1 + L + P, "R6 pulse width");
        at_cycle(c0 + 150); cs_n = 1'b0;
        at_cycle(c0 + 160); cs_n = 1'b1;
        // R5 period change restarts, R2 short period
        expect_edge(1'b1, c0 + 301 + S, "R5 R2 short time-out after change");
        expect_edge(1'b0, c0 + 301 + S + P, "R6 pulse width");
        at_cycle(c0 + 300); period_sel = 2'b10;
        // R2 middle period; R9 events inside pulse ignored
        expect_edge(1'b1, c0 + 341 + M, "R5 R2 middle time-out");
        expect_edge(1'b0, c0 + 341 + M + P, "R9 pulse unchanged by activity");
        expect_edge(1'b1, c0 + 341 + M + P + S, "R9 R6 count restarts after pulse");
        expect_edge(1'b0, c0 + 341 + M + P + S + P, "R6 pulse width");
        at_cycle(c0 + 340); period_sel = 2'b01;
        at_cycle(c0 + 403); cs_n = 1'b0; period_sel = 2'b10;
        at_cycle(c0 + 410); cs_n = 1'b1;
        // R3 disabled: no edge expected in the window
        at_cycle(c0 + 450); period_sel = 2'b11;
        at_cycle(c0 + 600); chk("R3 disabled", wd_reset, 1'b0);
        at_cycle(c0 + 700); chk("R3 disabled", wd_reset, 1'b0);
        period_sel = 2'b10;
        // R7 supply low forces, R8 release extends
        expect_edge(1'b1, c0 + 711, "R7 supply low forces reset");
        expect_edge(1'b0, c0 + 760 + 1 + P, "R8 pulse after release");
        expect_edge(1'b1, c0 + 767 + S, "R8 R6 count after hold");
        expect_edge(1'b0, c0 + 805 + 1 + P, "R9 R8 supply low inside pulse");
        expect_edge(1'b1, c0 + 812 + S, "R6 count after pulse");
        expect_edge(1'b0, c0 + 812 + S + P, "R6 pulse width");
        at_cycle(c0 + 710); supply_low = 1'b1;
        at_cycle(c0 + 759); chk("R7 held while supply low", wd_reset, 1'b1);
        at_cycle(c0 + 760); supply_low = 1'b0;
        at_cycle(c0 + 799); supply_low = 1'b1;
        at_cycle(c0 + 805); supply_low = 1'b0;
        at_cycle(c0 + 860);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R1-edge-list: %0d expected edges missing, expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end by 5000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule